// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host processor reach the management registers of Ethernet PHYs over the two-wire MDIO interface. The host sees two 32-bit registers on a simple single-cycle bus: a command register and a data register. To write a PHY register, software first puts the 16-bit value in the data register. It then writes a command word with the start bit set, which carries the PHY address, the register address, the operation and a clock-range code. The block shifts out a complete Clause 22 frame on MDC/MDIO and clears the busy bit when the last bit period has ended. For a read, the block releases the MDIO line from the turnaround onwards, shifts in the 16 bits the PHY returns, and places them in the data register before busy drops.

The clock-range code selects a fixed divide ratio, so that one controller can serve systems with different core clocks while keeping MDC within the management-interface limit. A build-time parameter chooses between two command-word layouts. In the default layout, a command word written with start clear makes the block issue one lone MDC period. Some PHYs need an MDC edge before they leave reset.

Top module: `mdio_master`

## Requirements
- R1: After reset both registers read 0, MDC is low and the MDIO output enable is low.
- R2: A command word with bit 0 set, written while idle, starts a frame. Bit 0 of the command register reads 1 from the clock after the write until the final MDC falling edge, which is 64 MDC periods later. MDC is low whenever the block is idle.
- R3: The 4-bit clock-range code gives the MDC period in system clocks: code 0→42, 1→62, 2→16, 3→26, 4→102, 5→124, and any other code→124. MDC is high for the second half of each period.
- R4: The frame is sent MSB first: 32 ones, then 01, then the opcode (01 write, 10 read), then the 5-bit PHY address, the 5-bit register address, the turnaround (10 on a write) and 16 data bits. The master changes MDIO only on MDC falling edges.
- R5: A write frame carries the data register value held at the start, and the master drives MDIO for all 64 bits.
- R6: On a read, the master releases MDIO (output enable low) for the turnaround and all 16 data bits. It samples MDIO at each MDC rising edge. The received value appears in data register bits 15:0, with the upper bits 0, by the time busy reads 0.
- R7: Default layout: PHY address in bits 15:11, register address in bits 10:6, clock-range code in bits 5:2, bit 1 set for write and clear for read.
- R8: Alternate layout: PHY address in bits 25:21, register address in bits 20:16, clock-range code in bits 11:8, operation in bits 3:2 (01 write, 11 read). A start with operation 00 or 10 launches nothing, and busy stays 0.
- R9: Default layout: a command write with bit 0 clear, made while idle, produces exactly one MDC period with MDIO released, and busy reads 1 for that period. In the alternate layout such a write produces no MDC activity.
- R10: Writes to either register while busy are ignored. The frame in progress, the command readback and the data register are all unaffected.
- R11: The bus address selects the register (0 command, 1 data), and read data is valid in the same cycle. The command register returns the last accepted word, with bit 0 replaced by the live busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 1 | Register select: 0 command, 1 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value sampled from the line |

## Verification
The bench attacks the turnaround boundary on reads. A design that keeps driving one bit too long would fight the PHY, and one that samples on the wrong MDC edge would return a value shifted by one bit. It also writes to both registers in the middle of a read frame. A design without the busy lock would either restart with a new divider, which shows up at once as an MDC edge at the wrong cycle, or overwrite the data that was just received. The clock-range code is exercised with a listed value and an unlisted one, so that a missing fallback gives a wrong MDC period. The lone-clock command is exercised in both layouts, and so is an alternate-layout start with an invalid operation, which a loose decoder would turn into a frame.

// File: rtl/mdio_pkg.sv
// Shared constants, types and the clock-range table for the MDIO master.
// Assumes Clause 22 framing only.
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int BUS_W      = 32;
    localparam int CSEL_W     = 4;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_POS     = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int DATA_POS   = TA_POS + 2;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int HALF_W     = 7;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_KICK  = 2'd3
    } mdio_op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [CSEL_W-1:0] csel;
        mdio_op_e          op;
    } mdio_cmd_t;

    // Half of the MDC period, in system clocks, for a clock-range code.
    function automatic logic [HALF_W-1:0] mdc_half(input logic [CSEL_W-1:0] code);
        logic [HALF_W-1:0] h;
        case (code)
            4'd0:    h = HALF_W'(21);
            4'd1:    h = HALF_W'(31);
            4'd2:    h = HALF_W'(8);
            4'd3:    h = HALF_W'(13);
            4'd4:    h = HALF_W'(51);
            default: h = HALF_W'(62);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/mdio_cmd_decode.sv
// Splits a 32-bit command word into PHY address, register address,
// clock-range code and operation. ALT_LAYOUT picks the field placement.
// Assumes the word is the raw bus write data.
module mdio_cmd_decode
    import mdio_pkg::*;
#(
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic [BUS_W-1:0] word,
    output mdio_cmd_t        cmd
);

    generate
        if (ALT_LAYOUT == 1'b0) begin : g_default
            logic unused_hi;
            assign unused_hi = ^word[BUS_W-1:16];
            // Default layout: write flag in bit 1; start clear means lone MDC clock.
            always_comb begin
                cmd.phy   = word[15:11];
                cmd.regad = word[10:6];
                cmd.csel  = word[5:2];
                if (!word[0])
                    cmd.op = OP_KICK;
                else if (word[1])
                    cmd.op = OP_WRITE;
                else
                    cmd.op = OP_READ;
            end
        end else begin : g_alt
            logic unused_rest;
            assign unused_rest = ^{word[BUS_W-1:26], word[15:12], word[7:4], word[1]};
            // Alternate layout: two-bit operation field; invalid codes launch nothing.
            always_comb begin
                cmd.phy   = word[25:21];
                cmd.regad = word[20:16];
                cmd.csel  = word[11:8];
                if (word[0] && word[3:2] == 2'b01)
                    cmd.op = OP_WRITE;
                else if (word[0] && word[3:2] == 2'b11)
                    cmd.op = OP_READ;
                else
                    cmd.op = OP_NONE;
            end
        end
    endgenerate

endmodule

// File: rtl/mdio_clkdiv.sv
// Produces a one-cycle tick every half MDC period while run is high.
// The counter restarts from zero whenever run is low, so the first tick
// comes exactly one half period after run rises.
module mdio_clkdiv
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CSEL_W-1:0] csel,
    output logic              hp_tick
);

    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half;

    assign half    = mdc_half(csel);
    assign hp_tick = run && (cnt_q == half - HALF_W'(1));

    // Half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || hp_tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + HALF_W'(1);
    end

endmodule

// File: rtl/mdio_frame_seq.sv
// Shifts out one Clause 22 frame (or a lone MDC period) per start pulse.
// MDIO changes on MDC falling edges; read data is sampled on rising edges.
// Assumes start is only raised while active is low.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    input  logic              hp_tick,
    output logic              active,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic [CSEL_W-1:0] csel
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] TA_BIT   = BIT_W'(TA_POS);
    localparam logic [BIT_W-1:0] DATA_BIT = BIT_W'(DATA_POS);

    logic                  active_q;
    logic                  mdc_q;
    mdio_op_e              op_q;
    logic [BIT_W-1:0]      bit_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [DATA_W-1:0]     rx_q;
    logic [CSEL_W-1:0]     csel_q;
    logic [FRAME_BITS-1:0] frame_init;
    logic                  last_fall;

    // Frame image assembled at start, MSB leaves first.
    always_comb begin
        frame_init = {{PRE_BITS{1'b1}}, 2'b01,
                      (cmd.op == OP_READ) ? 2'b10 : 2'b01,
                      cmd.phy, cmd.regad, 2'b10, wdata};
    end

    assign last_fall = active_q && hp_tick && mdc_q &&
                       (op_q == OP_KICK || bit_q == LAST_BIT);

    // Sequencer state: MDC phase, bit index, shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            mdc_q    <= 1'b0;
            op_q     <= OP_NONE;
            bit_q    <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            csel_q   <= '0;
        end else if (start && !active_q) begin
            active_q <= 1'b1;
            mdc_q    <= 1'b0;
            op_q     <= cmd.op;
            bit_q    <= '0;
            sh_q     <= frame_init;
            rx_q     <= '0;
            csel_q   <= cmd.csel;
        end else if (active_q && hp_tick) begin
            if (!mdc_q) begin
                mdc_q <= 1'b1;
                if (op_q == OP_READ && bit_q >= DATA_BIT)
                    rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            end else begin
                mdc_q <= 1'b0;
                if (last_fall) begin
                    active_q <= 1'b0;
                end else begin
                    bit_q <= bit_q + BIT_W'(1);
                    sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    assign active  = active_q;
    assign mdc     = mdc_q;
    assign mdio_o  = sh_q[FRAME_BITS-1];
    assign mdio_oe = active_q && (op_q == OP_WRITE || (op_q == OP_READ && bit_q < TA_BIT));
    assign done    = last_fall;
    assign rd_done = last_fall && op_q == OP_READ;
    assign rx_data = rx_q;
    assign csel    = csel_q;

endmodule

// File: rtl/mdio_master.sv
// Memory-mapped MDIO master: command and data registers on a single-cycle
// bus, a clock-range divider and a Clause 22 frame sequencer.
// Assumes one bus access per cycle; read data is combinational.
module mdio_master
    import mdio_pkg::*;
#(
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    mdio_cmd_t         dec_cmd;
    logic              seq_active;
    logic              seq_done;
    logic              seq_rd_done;
    logic              hp_tick;
    logic [DATA_W-1:0] seq_rx;
    logic [CSEL_W-1:0] seq_csel;
    logic              cmd_wr;
    logic              dat_wr;
    logic              start;
    logic [BUS_W-1:1]  cmd_word_q;
    logic [DATA_W-1:0] data_q;

    assign cmd_wr = bus_valid && bus_we && !bus_addr && !seq_active;
    assign dat_wr = bus_valid && bus_we &&  bus_addr && !seq_active;
    assign start  = cmd_wr && dec_cmd.op != OP_NONE;

    mdio_cmd_decode #(.ALT_LAYOUT(ALT_LAYOUT)) u_dec (
        .word (bus_wdata),
        .cmd  (dec_cmd)
    );

    mdio_clkdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (seq_active),
        .csel    (seq_csel),
        .hp_tick (hp_tick)
    );

    mdio_frame_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cmd     (dec_cmd),
        .wdata   (data_q),
        .mdio_i  (mdio_i),
        .hp_tick (hp_tick),
        .active  (seq_active),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_done (seq_rd_done),
        .done    (seq_done),
        .rx_data (seq_rx),
        .csel    (seq_csel)
    );

    // Command register: keeps the last word accepted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_word_q <= '0;
        else if (cmd_wr)
            cmd_word_q <= bus_wdata[BUS_W-1:1];
    end

    // Data register: host writes while idle, read result on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (seq_rd_done)
            data_q <= seq_rx;
        else if (dat_wr)
            data_q <= bus_wdata[DATA_W-1:0];
    end

    // Read mux with live busy bit.
    always_comb begin
        if (bus_addr)
            bus_rdata = {{(BUS_W-DATA_W){1'b0}}, data_q};
        else
            bus_rdata = {cmd_word_q, seq_active};
    end

endmodule

// File: rtl/mdio_master_chk.sv
// Assertion checker for mdio_master, attached by bind below.
// Assumes it sees the top's internal busy, tick and register state.
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_we,
    input logic              bus_addr,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic              hp_tick,
    input logic              seq_done,
    input logic [BUS_W-1:1]  cmd_word_q,
    input logic [DATA_W-1:0] data_q
);

    assert_idle_mdc_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_oe_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    assert_mdc_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hp_tick |=> $stable(mdc));

    assert_mdio_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

    assert_cmd_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_valid && bus_we && !bus_addr) |=> $stable(cmd_word_q));

    assert_data_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_done && bus_valid && bus_we && bus_addr) |=> $stable(data_q));

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .busy       (seq_active),
    .hp_tick    (hp_tick),
    .seq_done   (seq_done),
    .cmd_word_q (cmd_word_q),
    .data_q     (data_q)
);

// File: tb/mdio_master_tb_top.sv
// Bench: one instance per layout, a behavioural busy/MDC model checked on
// every clock, and a PHY responder that records frames and answers reads.
module mdio_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld [2];
    logic        bus_we = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd [2];
    logic        mdcw [2];
    logic        mo [2];
    logic        oe [2];
    logic        mi [2];

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // Reference model state
    bit m_busy [2];
    int m_n [2];
    int m_len [2];
    int m_half [2];

    // Responder state
    int          rc [2];
    logic [63:0] cap [2];
    logic [63:0] capoe [2];
    logic [15:0] phyval [2];

    always #2 clk = ~clk;

    mdio_master #(.ALT_LAYOUT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(vld[0]), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd[0]),
        .mdc(mdcw[0]), .mdio_o(mo[0]), .mdio_oe(oe[0]), .mdio_i(mi[0]));

    mdio_master #(.ALT_LAYOUT(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(vld[1]), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd[1]),
        .mdc(mdcw[1]), .mdio_o(mo[1]), .mdio_oe(oe[1]), .mdio_i(mi[1]));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R3 table: half of the MDC period for a code.
    function automatic int half_of(input logic [3:0] c);
        case (c)
            4'd0: return 21;
            4'd1: return 31;
            4'd2: return 8;
            4'd3: return 13;
            4'd4: return 51;
            default: return 62;
        endcase
    endfunction

    function automatic logic [31:0] mk0(input logic [4:0] p, input logic [4:0] r, input logic [3:0] c, input bit wr, input bit go);
        return {16'h0, p, r, c, wr, go};
    endfunction

    function automatic logic [31:0] mk1(input logic [4:0] p, input logic [4:0] r, input logic [3:0] c, input logic [1:0] op);
        return {6'h0, p, r, 4'h0, c, 4'h0, op, 1'b0, 1'b1};
    endfunction

    function automatic logic [63:0] frame(input bit rdop, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, rdop ? 2'b10 : 2'b01, p, r, 2'b10, d};
    endfunction

    // Behavioural model of busy and MDC, advanced on each clock edge.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            bit was_busy;
            was_busy = m_busy[i];
            if (!rst_n) begin
                m_busy[i] = 0;
                m_n[i] = 0;
            end else begin
                if (m_busy[i]) begin
                    m_n[i]++;
                    if (m_n[i] == m_len[i]) m_busy[i] = 0;
                end
                if (vld[i] && bus_we && !bus_addr && !was_busy) begin
                    if (i == 0) begin
                        m_half[i] = half_of(bus_wdata[5:2]);
                        m_len[i] = bus_wdata[0] ? 128 * m_half[i] : 2 * m_half[i];
                        m_busy[i] = 1;
                        m_n[i] = 0;
                    end else if (bus_wdata[0] && bus_wdata[2]) begin
                        m_half[i] = half_of(bus_wdata[11:8]);
                        m_len[i] = 128 * m_half[i];
                        m_busy[i] = 1;
                        m_n[i] = 0;
                    end
                end
            end
        end
    end

    // Per-clock comparison against the model (R2, R3, R9).
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            for (int i = 0; i < 2; i++) begin
                logic emdc;
                emdc = m_busy[i] && (((m_n[i] / m_half[i]) % 2) == 1);
                chk(mdcw[i] === emdc, "R3 mdc timing", {63'b0, mdcw[i]}, {63'b0, emdc});
                if (!bus_addr)
                    chk(rd[i][0] === m_busy[i], "R2 busy bit", {63'b0, rd[i][0]}, {63'b0, m_busy[i]});
                if (!m_busy[i])
                    chk(oe[i] === 1'b0, "R2 idle oe", {63'b0, oe[i]}, 64'd0);
            end
        end
    end

    // PHY responder: records rising-edge bits, answers read data after falls.
    for (genvar g = 0; g < 2; g++) begin : g_phy
        always @(posedge mdcw[g]) begin
            if (rc[g] < 64) begin
                cap[g][63 - rc[g]]   = mo[g];
                capoe[g][63 - rc[g]] = oe[g];
            end
            rc[g]++;
        end
        always @(negedge mdcw[g]) begin
            if (rc[g] >= 48 && rc[g] <= 63) mi[g] = phyval[g][63 - rc[g]];
        end
    end

    task automatic wr(input int i, input bit a, input logic [31:0] d);
        @(negedge clk);
        vld[i] = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        vld[i] = 1'b0; bus_we = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic rdreg(input int i, input bit a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = rd[i];
        bus_addr = 1'b0;
    endtask

    task automatic wait_idle(input int i);
        @(negedge clk);
        while (m_busy[i]) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic start_cmd(input int i, input logic [31:0] w);
        rc[i] = 0; cap[i] = '0; capoe[i] = '0;
        wr(i, 1'b0, w);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        vld[0] = 0; vld[1] = 0; mi[0] = 0; mi[1] = 0;
        rc[0] = 0; rc[1] = 0; phyval[0] = '0; phyval[1] = '0;
        m_half[0] = 1; m_half[1] = 1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 2; i++) begin
            rdreg(i, 1'b0, v); chk(v === 32'h0, "R1 cmd reset", {32'h0, v}, 64'h0);
            rdreg(i, 1'b1, v); chk(v === 32'h0, "R1 data reset", {32'h0, v}, 64'h0);
            chk(mdcw[i] === 1'b0 && oe[i] === 1'b0, "R1 pins reset", {62'h0, mdcw[i], oe[i]}, 64'h0);
        end

        // R5 R7 default-layout write
        wr(0, 1'b1, 32'h0000_A5C3);
        w = mk0(5'h12, 5'h07, 4'd2, 1'b1, 1'b1);
        start_cmd(0, w);
        wait_idle(0);
        chk(cap[0] === frame(1'b0, 5'h12, 5'h07, 16'hA5C3), "R4 R7 write frame", cap[0], frame(1'b0, 5'h12, 5'h07, 16'hA5C3));
        chk(capoe[0] === 64'hFFFF_FFFF_FFFF_FFFF, "R5 write drives all bits", capoe[0], 64'hFFFF_FFFF_FFFF_FFFF);
        chk(rc[0] == 64, "R2 64 MDC periods", 64'(rc[0]), 64'd64);
        rdreg(0, 1'b0, v); chk(v === (w & ~32'h1), "R11 cmd readback", {32'h0, v}, {32'h0, w & ~32'h1});
        rdreg(0, 1'b1, v); chk(v === 32'h0000_A5C3, "R5 data kept", {32'h0, v}, 64'h0000_A5C3);

        // R6 default-layout read with writes while busy (R10)
        phyval[0] = 16'h3C5A;
        w = mk0(5'h01, 5'h1F, 4'd3, 1'b0, 1'b1);
        start_cmd(0, w);
        repeat (100) @(negedge clk);
        wr(0, 1'b0, mk0(5'h0A, 5'h0A, 4'd0, 1'b1, 1'b1));
        wr(0, 1'b1, 32'h0000_FFFF);
        wait_idle(0);
        chk(cap[0][63:18] === frame(1'b1, 5'h01, 5'h1F, 16'h0)[63:18], "R4 R7 read header", cap[0], frame(1'b1, 5'h01, 5'h1F, 16'h0));
        chk(capoe[0] === 64'hFFFF_FFFF_FFFC_0000, "R6 released from turnaround", capoe[0], 64'hFFFF_FFFF_FFFC_0000);
        rdreg(0, 1'b1, v); chk(v === 32'h0000_3C5A, "R6 read data", {32'h0, v}, 64'h3C5A);
        rdreg(0, 1'b0, v); chk(v === (w & ~32'h1), "R10 cmd unchanged", {32'h0, v}, {32'h0, w & ~32'h1});

        // R3 unlisted clock-range code falls back to the slowest divider
        phyval[0] = 16'h8001;
        start_cmd(0, mk0(5'h1F, 5'h00, 4'd9, 1'b0, 1'b1));
        wait_idle(0);
        rdreg(0, 1'b1, v); chk(v === 32'h0000_8001, "R3 R6 slow read", {32'h0, v}, 64'h8001);

        // R9 zero command in default layout: one lone MDC period
        start_cmd(0, 32'h0);
        wait_idle(0);
        chk(rc[0] == 1, "R9 one MDC period", 64'(rc[0]), 64'd1);
        chk(capoe[0][63] === 1'b0, "R9 MDIO released", {63'h0, capoe[0][63]}, 64'h0);

        // R8 alternate-layout write
        wr(1, 1'b1, 32'h0000_1234);
        w = mk1(5'h0B, 5'h15, 4'd2, 2'b01);
        start_cmd(1, w);
        wait_idle(1);
        chk(cap[1] === frame(1'b0, 5'h0B, 5'h15, 16'h1234), "R8 alt write frame", cap[1], frame(1'b0, 5'h0B, 5'h15, 16'h1234));
        rdreg(1, 1'b0, v); chk(v === (w & ~32'h1), "R11 alt readback", {32'h0, v}, {32'h0, w & ~32'h1});

        // R8 alternate-layout read
        phyval[1] = 16'hBEEF;
        start_cmd(1, mk1(5'h1E, 5'h02, 4'd4, 2'b11));
        wait_idle(1);
        chk(cap[1][63:18] === frame(1'b1, 5'h1E, 5'h02, 16'h0)[63:18], "R8 alt read header", cap[1], frame(1'b1, 5'h1E, 5'h02, 16'h0));
        rdreg(1, 1'b1, v); chk(v === 32'h0000_BEEF, "R8 alt read data", {32'h0, v}, 64'hBEEF);

        // R8 invalid operation launches nothing; R9 alt zero write idle
        start_cmd(1, mk1(5'h03, 5'h03, 4'd2, 2'b10));
        repeat (40) @(negedge clk);
        chk(rc[1] == 0, "R8 invalid op no frame", 64'(rc[1]), 64'd0);
        rdreg(1, 1'b0, v); chk(v[0] === 1'b0, "R8 invalid op not busy", {63'h0, v[0]}, 64'h0);
        start_cmd(1, 32'h0);
        repeat (60) @(negedge clk);
        chk(rc[1] == 0, "R9 alt zero write silent", 64'(rc[1]), 64'd0);
        rdreg(1, 1'b1, v); chk(v === 32'h0000_BEEF, "R8 data unchanged", {32'h0, v}, 64'hBEEF);

        ended = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule